// File: doc/BRIEF.md
# Bidirectional Registered Bus Transceiver

This block sits between two buses, called A and B, and passes data between them through two independent storage registers. One register carries data from A towards B, the other from B towards A. Each direction has its own clock, its own active-low chip enable and its own active-low output enable. The two paths can therefore be loaded and driven at different times without affecting each other.

A register loads its input port at the rising edge of its direction's clock, but only while that direction's chip enable is low. The opposite port is driven only while both the chip enable and the output enable of that direction are low. When driven, the port shows the stored value, never the live level of the input bus. The core keeps input, output and drive-enable signals separate for each port, so a chip-level pad ring or tri-state wrapper can join them into bidirectional pins. An active-low asynchronous reset clears both registers.

Top module: `bus_xcvr_reg`

## Requirements
- R1: When `rst_n` is low, both registers clear to zero at once, without waiting for a clock edge. `b_out` and `a_out` then read 0.
- R2: At a rising edge of `clk_ab` with `ce_ab_n` low, the A-to-B register loads `a_in`. `b_out` shows the loaded value after that edge.
- R3: At a rising edge of `clk_ab` with `ce_ab_n` high, the A-to-B register keeps its contents, whatever `a_in` holds.
- R4: `b_drv` is 1 exactly when both `ce_ab_n` and `oe_ab_n` are 0, and is 0 for the other three combinations. `b_out` always carries the stored A-to-B value, never the current `a_in`.
- R5: At a rising edge of `clk_ba` with `ce_ba_n` low, the B-to-A register loads `b_in`. `a_out` shows the loaded value after that edge.
- R6: At a rising edge of `clk_ba` with `ce_ba_n` high, the B-to-A register keeps its contents, whatever `b_in` holds.
- R7: `a_drv` is 1 exactly when both `ce_ba_n` and `oe_ba_n` are 0, and is 0 for the other three combinations. `a_out` always carries the stored B-to-A value.
- R8: Changing any enable between clock edges never changes stored contents. The enables and data of one direction never affect the register of the other direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous reset, active low; clears both registers |
| clk_ab | input | 1 | Load clock of the A-to-B register |
| ce_ab_n | input | 1 | A-to-B chip enable, active low; gates both loading and driving |
| oe_ab_n | input | 1 | A-to-B output enable, active low |
| a_in | input | WIDTH | Level currently present on bus A |
| b_out | output | WIDTH | Stored A-to-B value, presented to bus B |
| b_drv | output | 1 | Drive enable for bus B; 0 means high impedance |
| clk_ba | input | 1 | Load clock of the B-to-A register |
| ce_ba_n | input | 1 | B-to-A chip enable, active low; gates both loading and driving |
| oe_ba_n | input | 1 | B-to-A output enable, active low |
| b_in | input | WIDTH | Level currently present on bus B |
| a_out | output | WIDTH | Stored B-to-A value, presented to bus A |
| a_drv | output | 1 | Drive enable for bus A; 0 means high impedance |

## Verification
The bench steps all four combinations of chip enable and output enable in each direction. A design that drives the port with only the output enable low, or that ignores the chip enable when driving, shows a wrong drive flag in one of these combinations. The bench changes the input bus with the chip enable high, and again just before an edge after a load. A design that passes the live bus through, or that loads while disabled, then shows a value different from the last stored one. The bench also resets mid-run without a clock edge, and runs the two directions with different enables at once, so that a synchronous reset or a mix-up between directions shows up.

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg #(
  parameter int WIDTH = 8
) (
  input  logic             rst_n,
  input  logic             clk_ab,
  input  logic             ce_ab_n,
  input  logic             oe_ab_n,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_drv,
  input  logic             clk_ba,
  input  logic             ce_ba_n,
  input  logic             oe_ba_n,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_drv
);

  logic [WIDTH-1:0] hold_ab;
  logic [WIDTH-1:0] hold_ba;

  always_ff @(posedge clk_ab or negedge rst_n) begin
    if (!rst_n)        hold_ab <= '0;
    else if (!ce_ab_n) hold_ab <= a_in;
  end

  always_ff @(posedge clk_ba or negedge rst_n) begin
    if (!rst_n)        hold_ba <= '0;
    else if (!ce_ba_n) hold_ba <= b_in;
  end

  assign b_out = hold_ab;
  assign a_out = hold_ba;
  assign b_drv = ~(ce_ab_n | oe_ab_n);
  assign a_drv = ~(ce_ba_n | oe_ba_n);

  AST_AB_LOAD: assert property (@(posedge clk_ab) disable iff (!rst_n)
    !ce_ab_n |=> b_out == $past(a_in)); // R2
  AST_AB_HOLD: assert property (@(posedge clk_ab) disable iff (!rst_n)
    ce_ab_n |=> $stable(b_out)); // R3
  AST_AB_NODRV: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (ce_ab_n || oe_ab_n) |-> !b_drv); // R4
  AST_BA_LOAD: assert property (@(posedge clk_ba) disable iff (!rst_n)
    !ce_ba_n |=> a_out == $past(b_in)); // R5
  AST_BA_HOLD: assert property (@(posedge clk_ba) disable iff (!rst_n)
    ce_ba_n |=> $stable(a_out)); // R6
  AST_BA_NODRV: assert property (@(posedge clk_ba) disable iff (!rst_n)
    (ce_ba_n || oe_ba_n) |-> !a_drv); // R7
  AST_RST_CLEAR: assert property (@(posedge clk_ab)
    !rst_n |-> (b_out == '0 && a_out == '0)); // R1

endmodule

// File: tb/sim_bus_xcvr_reg.sv
module sim_bus_xcvr_reg;
  localparam int W = 8;

  logic clk = 0;
  logic rst_n = 0;
  logic ce_ab_n = 1, oe_ab_n = 1, ce_ba_n = 1, oe_ba_n = 1;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] b_out, a_out;
  logic b_drv, a_drv;
  logic clk_ab, clk_ba;

  assign clk_ab = clk;
  assign clk_ba = clk;
  always #2 clk = ~clk;

  bus_xcvr_reg #(.WIDTH(W)) u0 (
    .rst_n(rst_n), .clk_ab(clk_ab), .ce_ab_n(ce_ab_n), .oe_ab_n(oe_ab_n),
    .a_in(a_in), .b_out(b_out), .b_drv(b_drv),
    .clk_ba(clk_ba), .ce_ba_n(ce_ba_n), .oe_ba_n(oe_ba_n),
    .b_in(b_in), .a_out(a_out), .a_drv(a_drv)
  );

  typedef struct {
    logic [W-1:0] eb;
    logic         ebd;
    logic [W-1:0] ea;
    logic         ead;
    string        tag;
  } item_t;

  item_t q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [W-1:0] m_ab = '0, m_ba = '0;

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic cab, input logic oab, input logic [W-1:0] a,
                      input logic cba, input logic oba, input logic [W-1:0] b,
                      input string tag);
    item_t it;
    @(negedge clk);
    ce_ab_n = cab; oe_ab_n = oab; a_in = a;
    ce_ba_n = cba; oe_ba_n = oba; b_in = b;
    if (!cab) m_ab = a;
    if (!cba) m_ba = b;
    it.eb = m_ab; it.ebd = !cab && !oab;
    it.ea = m_ba; it.ead = !cba && !oba;
    it.tag = tag;
    q.push_back(it);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        it = q.pop_front();
        chk({it.tag, " b_out"}, b_out, it.eb);
        chk({it.tag, " b_drv"}, {{(W-1){1'b0}}, b_drv}, {{(W-1){1'b0}}, it.ebd});
        chk({it.tag, " a_out"}, a_out, it.ea);
        chk({it.tag, " a_drv"}, {{(W-1){1'b0}}, a_drv}, {{(W-1){1'b0}}, it.ead});
      end
    end
  end

  initial begin : watchdog
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    chk("R1 reset b_out", b_out, '0);
    chk("R1 reset a_out", a_out, '0);
    rst_n = 1;
    step(1, 0, 8'hA5, 1, 0, 8'h5A, "R1 hold after reset");
    step(0, 0, 8'h3C, 1, 1, 8'h11, "R2 load A");
    step(0, 1, 8'hC3, 1, 1, 8'h22, "R2 load A oe high");
    step(1, 0, 8'hFF, 1, 1, 8'h33, "R3 ignore A ce high");
    step(1, 1, 8'h00, 1, 1, 8'h44, "R3 ignore A both high");
    step(1, 1, 8'h81, 0, 0, 8'h7E, "R5 load B");
    step(1, 1, 8'h82, 0, 1, 8'h99, "R5 load B oe high");
    step(1, 1, 8'h83, 1, 0, 8'hEE, "R6 ignore B ce high");
    step(1, 1, 8'h84, 1, 1, 8'h01, "R6 ignore B both high");
    for (int i = 0; i < 4; i++) begin
      step(i[1], i[0], 8'h10 + 8'(i), i[0], i[1], 8'h20 + 8'(i), "R4 R7 R8 enable combo");
    end
    step(0, 0, 8'h5F, 1, 0, 8'hF5, "R8 A loads B holds");
    step(1, 0, 8'h60, 0, 0, 8'h06, "R8 B loads A holds");
    for (int i = 0; i < 6; i++) begin
      step(0, 0, 8'(i * 37 + 1), 0, 0, 8'(255 - i * 29), "R2 R5 stream");
    end
    @(negedge clk);
    ce_ab_n = 1; ce_ba_n = 1;
    @(posedge clk); #1;
    a_in = ~m_ab; b_in = ~m_ba; #1;
    chk("R4 live A not shown", b_out, m_ab);
    chk("R7 live B not shown", a_out, m_ba);
    oe_ab_n = 0; ce_ab_n = 0; oe_ba_n = 0; ce_ba_n = 0; #1;
    chk("R8 enable change keeps A-to-B", b_out, m_ab);
    chk("R8 enable change keeps B-to-A", a_out, m_ba);
    ce_ab_n = 1; ce_ba_n = 1;
    @(negedge clk);
    rst_n = 0; #1;
    chk("R1 async clear b_out", b_out, '0);
    chk("R1 async clear a_out", a_out, '0);
    m_ab = '0; m_ba = '0;
    @(negedge clk);
    rst_n = 1;
    step(1, 0, 8'h77, 1, 0, 8'h88, "R1 R3 R6 hold after mid reset");
    step(0, 0, 8'h99, 0, 0, 8'hAA, "R2 R5 load after mid reset");
    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule